// File: doc/BRIEF.md
# Programmable PWM Channel

This block produces one pulse-width-modulated output from a free-running up/down counter. The counter is compared against a programmed cycle length and an active-phase length. Software programs it through four 32-bit word registers: a read-only view of the counter, the cycle length, the active length, and a control word. The counter advances only in cycles where an external clock-enable strobe (`tick`) is high, so a separate divider sets the time base.

The control word chooses continuous or one-shot operation, left-edge or symmetric (center) counting, the output level during the active phase, and the level held while the channel is stopped. In one-shot mode the channel runs a programmed number of full cycles and then clears its own run bit. A capture selection is accepted, but it only parks the output at the stopped level. New cycle-length and active-length values are taken up only at a cycle boundary, so the output never shows a truncated or stretched cycle.

Top module: `pwm_chan`

## Requirements
- R1: Registers sit at byte offsets 0x0 (counter, read-only; writes have no effect), 0x4 (cycle length), 0x8 (active length) and 0xC (control). Cycle length, active length and control read back the value last written.
- R2: While control bit 0 (run) is 0, the counter reads 0 and `pwm_out` equals control bit 4 (stopped level). After reset every register is 0, so `pwm_out` is 0.
- R3: With control bit 5 = 0 (left), the counter steps 0,1,..,L-1 and then returns to 0, where L is the cycle length. The phase is active while counter < active length.
- R4: With control bit 5 = 1 (center), the counter steps 0,1,..,L and then back down L-1,..,1, so one cycle lasts 2L ticks. The phase is active while counter < active length.
- R5: Control bit 3 gives the output level in the active phase. The inactive phase drives the opposite level.
- R6: An active length of 0 keeps the phase inactive for the whole cycle. An active length greater than or equal to L keeps it active for the whole cycle.
- R7: A cycle or active length written while running is used only from the next cycle boundary. The current cycle finishes with the old values.
- R8: Control bits [2:1] = 00 select one-shot mode. The channel runs N+1 full cycles, where N is control bits [31:24], then clears control bit 0 and drives the stopped level. Bits [2:1] = 01 select continuous running.
- R9: Control bits [2:1] = 10 (capture) or 11 with run set hold the counter at 0 and drive the stopped level.
- R10: The counter changes only on cycles where `tick` is 1. With `tick` low it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance strobe from a divider |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
The waveform is checked sample by sample under these settings:
- A left-aligned ratio below half, against a center-aligned run. This shows whether the counter turns around at L or wraps.
- Both polarities, to show whether active and inactive levels are swapped.
- An active length of zero and one exactly equal to L, to expose off-by-one compares at the edges of the duty range.

A mid-cycle change of cycle length shows whether the update waits for the boundary. A one-shot run with a stopped level opposite the inactive level shows the exact cycle in which the channel stops. A capture selection and a gated strobe confirm that the counter freezes.

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pwm_out
);

  localparam logic [3:0] A_CNT  = 4'h0;
  localparam logic [3:0] A_LEN  = 4'h4;
  localparam logic [3:0] A_ACT  = 4'h8;
  localparam logic [3:0] A_CTRL = 4'hC;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt, len_r, act_r, len_a, act_a;
  logic [31:0]  ctrl;
  logic [7:0]   shots;
  logic         down;

  wire       en      = ctrl[0];
  wire [1:0] mode    = ctrl[2:1];
  wire       pol     = ctrl[3];
  wire       idle    = ctrl[4];
  wire       center  = ctrl[5];
  wire [7:0] rep     = ctrl[31:24];
  wire       run     = en && !mode[1];
  wire       oneshot = (mode == 2'b00);
  wire       wr_ctrl = wr_en && (addr == A_CTRL);
  wire [W-1:0] len_m1 = len_a - ONE;

  wire wrap = run && tick &&
              ((len_a == '0) || (center ? (down && cnt <= ONE) : (cnt >= len_m1)));
  wire turn = run && tick && center && !down && (len_a != '0) && (cnt >= len_m1);
  wire last = wrap && oneshot && (shots == rep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (!run || wrap) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      if (turn) begin
        cnt  <= len_a;
        down <= 1'b1;
      end else if (down) begin
        cnt <= cnt - ONE;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_a <= '0;
      act_a <= '0;
    end else if (!run || wrap) begin
      len_a <= len_r;
      act_a <= act_r;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                shots <= '0;
    else if (!run)             shots <= '0;
    else if (wrap && oneshot)  shots <= last ? 8'd0 : shots + 8'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_r <= '0;
      act_r <= '0;
      ctrl  <= '0;
    end else begin
      if (wr_en && addr == A_LEN) len_r <= wdata[W-1:0];
      if (wr_en && addr == A_ACT) act_r <= wdata[W-1:0];
      if (wr_ctrl)     ctrl    <= wdata;
      else if (last)   ctrl[0] <= 1'b0;
    end
  end

  wire active = (act_a != '0) && ((act_a >= len_a) || (cnt < act_a));
  assign pwm_out = run ? (active ? pol : ~pol) : idle;

  always_comb begin
    case (addr)
      A_CNT:   rdata = 32'(cnt);
      A_LEN:   rdata = 32'(len_r);
      A_ACT:   rdata = 32'(act_r);
      A_CTRL:  rdata = ctrl;
      default: rdata = '0;
    endcase
  end

  p_step_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && !center && !wrap |=> cnt == $past(cnt) + ONE);

  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run && !wrap |=> $stable(len_a) && $stable(act_a));

  p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last && !wr_ctrl |=> !ctrl[0] && pwm_out == ctrl[4]);

  p_capture_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en && mode[1] |=> cnt == '0);

  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(cnt));

endmodule

// File: tb/test_pwm_chan.sv
module test_pwm_chan;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out;

  pwm_chan i_pwm_chan (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                       .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #(CLK_P/2) clk = ~clk;

  typedef struct { logic v; string req; } exp_t;
  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, {31'd0, pwm_out}, {31'd0, e.v});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic push_v(logic v, int n, string req);
    for (int j = 0; j < n; j++) q.push_back('{v, req});
  endtask

  task automatic push_left(int len, int act, logic pol, int n, string req);
    for (int j = 0; j < n; j++) begin
      int c = j % len;
      logic a = (act != 0) && (act >= len || c < act);
      q.push_back('{a ? pol : ~pol, req});
    end
  endtask

  task automatic push_center(int len, int act, logic pol, int n, string req);
    for (int j = 0; j < n; j++) begin
      int k = j % (2 * len);
      int c = (k <= len) ? k : 2 * len - k;
      logic a = (act != 0) && (act >= len || c < act);
      q.push_back('{a ? pol : ~pol, req});
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    #1;
  endtask

  task automatic setup(int len, int act);
    wr(4'hC, 32'h0);
    wr(4'h4, len);
    wr(4'h8, act);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 reset state
    check("R2", {31'd0, pwm_out}, 32'd0);
    rd(4'hC, 32'h0, "R2");
    rd(4'h0, 32'h0, "R2");

    // R1 register map and read-only counter
    wr(4'h4, 32'd5);
    wr(4'h8, 32'd2);
    wr(4'h0, 32'hDEAD);
    rd(4'h4, 32'd5, "R1");
    rd(4'h8, 32'd2, "R1");
    rd(4'h0, 32'd0, "R1");
    wr(4'hC, 32'h10);
    rd(4'hC, 32'h10, "R1");
    check("R2", {31'd0, pwm_out}, 32'd1);

    // R3 left aligned continuous, high active
    wr(4'hC, 32'h0B);
    push_left(5, 2, 1'b1, 15, "R3");
    drain();
    wr(4'hC, 32'h10);
    check("R2", {31'd0, pwm_out}, 32'd1);
    repeat (2) @(posedge clk); #1;
    rd(4'h0, 32'd0, "R2");

    // R5 low active polarity
    setup(4, 1);
    wr(4'hC, 32'h03);
    push_left(4, 1, 1'b0, 12, "R5");
    drain();

    // R6 active length equal to cycle length, then zero
    setup(4, 4);
    wr(4'hC, 32'h0B);
    push_v(1'b1, 8, "R6");
    drain();
    setup(4, 0);
    wr(4'hC, 32'h03);
    push_v(1'b1, 8, "R6");
    drain();

    // R4 center aligned
    setup(3, 2);
    wr(4'hC, 32'h2B);
    push_center(3, 2, 1'b1, 18, "R4");
    drain();

    // R7 cycle length change deferred to boundary
    setup(4, 2);
    wr(4'hC, 32'h0B);
    push_left(4, 2, 1'b1, 8, "R7");
    push_left(6, 2, 1'b1, 12, "R7");
    repeat (4) @(posedge clk);
    wr(4'h4, 32'd6);
    drain();

    // R8 one-shot with repeat 2, stopped level high
    setup(3, 1);
    wr(4'hC, 32'h0200_0019);
    push_left(3, 1, 1'b1, 9, "R8");
    push_v(1'b1, 4, "R8");
    drain();
    rd(4'hC, 32'h0200_0018, "R8");

    // R9 capture selection parks output
    wr(4'hC, 32'h1D);
    push_v(1'b1, 6, "R9");
    drain();
    rd(4'h0, 32'd0, "R9");

    // R10 tick gating
    setup(5, 2);
    tick = 1'b0;
    wr(4'hC, 32'h0B);
    push_v(1'b1, 5, "R10");
    drain();
    rd(4'h0, 32'd0, "R10");
    tick = 1'b1;
    repeat (3) @(posedge clk);
    #1 tick = 1'b0;
    rd(4'h0, 32'd3, "R10");
    repeat (3) @(posedge clk); #1;
    rd(4'h0, 32'd3, "R10");
    tick = 1'b1;
    wr(4'hC, 32'h0);

    finish_run();
  end
endmodule